// File: doc/BRIEF.md
# Stack Local-Variable Load/Store Unit

This unit executes three stack-machine operations against a word-addressed data memory: pushing a signed byte constant, copying a local variable onto the stack, and popping the stack top into a local variable. It receives an operation that has already been decoded, together with one or two index/immediate bytes and a wide flag. It keeps its own stack pointer, local-variable base, top-of-stack copy, memory address register and memory data register.

A single 32-bit operand bus carries the incoming byte into the datapath. On a byte push, the byte is sign-extended onto the bus. On a local-variable access, the byte is treated as an unsigned index and the upper bits are filled with zeros. When the wide flag is set, a 16-bit unsigned index is formed, high byte first. The stack pointer and address register are updated while a memory read is still in flight. The unit pulses a completion strobe once every register and memory update of the operation has finished. It accepts a new operation only while it is idle.

The memory port uses a request strobe, a write enable, an address and write data. Read data comes back with a valid strobe exactly one cycle after a read request.

Top module: `lvar_stack_unit`

## Requirements
- R1: Byte push (op_kind 1) copies bit 7 of `imm_lo` into bits 31..8. It increments the stack pointer, writes the extended value to memory at the new stack pointer, and loads it into the top-of-stack register.
- R2: The signed and unsigned extension selects are never active together. Push uses the signed select. Load and store use the unsigned select, so a narrow index of 0x80..0xFF addresses above the base.
- R3: Narrow local load (op_kind 2, wide 0) reads the word at base + `imm_lo`, taken as an unsigned index.
- R4: Local load increments the stack pointer and writes the loaded word to the new stack-pointer address. The same word ends up in the top-of-stack register, and the pre-load word is the one copied, even when the source address equals the new stack slot.
- R5: Local store (op_kind 3) writes the top-of-stack value to base + index and decrements the stack pointer. It then reloads top-of-stack from memory at the decremented stack pointer. The write comes before the read, so when the two addresses match, the new top-of-stack equals the stored value.
- R6: With wide set, the index for load and store is {`imm_hi`, `imm_lo`}, unsigned, high byte first.
- R7: A byte push ignores the wide flag and `imm_hi`.
- R8: `op_done` is high for exactly one cycle. The accepting edge is cycle 0. Done falls in cycle 3 for a push and in cycle 4 for a load or store.
- R9: `op_valid` is ignored while `busy` is high, so an operation offered during busy leaves no trace. Op_kind 0 is never accepted.
- R10: Read data is captured from the memory port only when `mem_rvalid` is high. The memory returns it one cycle after the read request.
- R11: After reset, the stack pointer equals SP_INIT, top-of-stack is zero, and `busy`, `op_done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_kind | input | 2 | 0 none, 1 byte push, 2 local load, 3 local store |
| op_wide | input | 1 | 16-bit index for load/store |
| imm_hi | input | 8 | High index byte (wide only) |
| imm_lo | input | 8 | Immediate byte or low index byte |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| sp_o | output | AW | Current stack pointer |
| tos_o | output | DW | Current top-of-stack register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
Two pairs of accesses can hit the same memory word in back-to-back cycles. In a store, the variable write and the new-top read collide when base + index equals the decremented stack pointer. In a load, the variable read and the stack write collide when base + index equals the incremented stack pointer. The bench works out both indices from its own model of the stack pointer and issues them as directed cases. In the store case it expects the stored value as the new top-of-stack. In the load case it expects the pre-load word. Random operations also hit the extension boundary bytes and offer a second operation while the unit is busy.

// File: rtl/lvar_pkg.sv
// Package: shared operation codes, controller states and control strobes for
// the local-variable load/store unit. Assumes 8-bit immediate bytes.
package lvar_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LV_OP_NONE  = 2'd0,
        LV_OP_PUSH  = 2'd1,
        LV_OP_LOAD  = 2'd2,
        LV_OP_STORE = 2'd3
    } lv_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_UPD,
        S_PUSH_WR,
        S_LD_RD,
        S_LD_WAIT,
        S_LD_WR,
        S_ST_WR,
        S_ST_RD,
        S_ST_WAIT,
        S_FIN
    } lv_state_e;

    // Control strobes from the controller to the register file.
    typedef struct packed {
        logic sel_sx;       // operand bus: sign-extend byte
        logic sel_zx;       // operand bus: zero-fill index
        logic mdr_from_bus; // capture push constant
        logic mar_from_idx; // address := base + index
        logic sp_inc;       // stack pointer + 1, copied to address reg
        logic sp_dec;       // stack pointer - 1, copied to address reg
        logic tos_from_mdr; // top-of-stack := data reg
        logic mem_cap;      // data reg and top-of-stack := read data
        logic mem_rd;       // issue read at address reg
        logic mem_wr;       // issue write at address reg
        logic wsel_tos;     // write data from top-of-stack (else data reg)
    } lv_ctl_t;

endpackage

// File: rtl/lvar_operand_ext.sv
// Module: lvar_operand_ext
// Drives the DW-bit operand bus from one or two immediate bytes. With the
// signed select the low byte is sign-extended; with the unsigned select the
// low byte (or the high/low pair when wide) is zero-filled. Assumes the two
// selects are exclusive; with neither active the bus is zero.
module lvar_operand_ext
    import lvar_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              sel_sx,
    input  logic              sel_zx,
    input  logic              wide,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    output logic [DW-1:0]     bus
);
    localparam int UPPER_N = DW - BYTE_W;
    localparam int WIDE_N  = DW - 2 * BYTE_W;

    logic [DW-1:0] sx_val;
    logic [DW-1:0] zx_narrow;
    logic [DW-1:0] zx_wide;

    // Build the three candidate extensions of the immediate bytes.
    always_comb begin
        sx_val    = {{UPPER_N{lo[BYTE_W-1]}}, lo};
        zx_narrow = {{UPPER_N{1'b0}}, lo};
        zx_wide   = {{WIDE_N{1'b0}}, hi, lo};
    end

    // Choose the bus value from the active select.
    always_comb begin
        if (sel_sx)
            bus = sx_val;
        else if (sel_zx)
            bus = wide ? zx_wide : zx_narrow;
        else
            bus = '0;
    end

endmodule

// File: rtl/lvar_ctrl.sv
// Module: lvar_ctrl
// Sequencer for push, load and store. Accepts an operation only in idle,
// steps through fixed per-operation states and raises done for one cycle in
// the final state. Assumes read data returns with mem_rvalid one cycle
// after a read request; the wait states hold until it arrives.
module lvar_ctrl
    import lvar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_valid,
    input  logic [1:0] op_kind,
    input  logic      mem_rvalid,
    output lv_ctl_t   ctl,
    output logic      busy,
    output logic      done
);
    lv_state_e state_q, state_d;
    lv_op_e    kind;
    logic      accept;

    assign kind   = lv_op_e'(op_kind);
    assign accept = (state_q == S_IDLE) && op_valid && (kind != LV_OP_NONE);

    // Next-state selection for each operation's sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    unique case (kind)
                        LV_OP_PUSH:  state_d = S_PUSH_UPD;
                        LV_OP_LOAD:  state_d = S_LD_RD;
                        LV_OP_STORE: state_d = S_ST_WR;
                        default:     state_d = S_IDLE;
                    endcase
                end
            end
            S_PUSH_UPD: state_d = S_PUSH_WR;
            S_PUSH_WR:  state_d = S_FIN;
            S_LD_RD:    state_d = S_LD_WAIT;
            S_LD_WAIT:  state_d = mem_rvalid ? S_LD_WR : S_LD_WAIT;
            S_LD_WR:    state_d = S_FIN;
            S_ST_WR:    state_d = S_ST_RD;
            S_ST_RD:    state_d = S_ST_WAIT;
            S_ST_WAIT:  state_d = mem_rvalid ? S_FIN : S_ST_WAIT;
            S_FIN:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Decode control strobes from the current state.
    always_comb begin
        ctl = '0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    ctl.sel_sx       = (kind == LV_OP_PUSH);
                    ctl.sel_zx       = (kind != LV_OP_PUSH);
                    ctl.mdr_from_bus = (kind == LV_OP_PUSH);
                    ctl.mar_from_idx = (kind != LV_OP_PUSH);
                end
            end
            S_PUSH_UPD: begin
                ctl.sp_inc       = 1'b1;
                ctl.tos_from_mdr = 1'b1;
            end
            S_PUSH_WR:  ctl.mem_wr = 1'b1;
            S_LD_RD: begin
                ctl.mem_rd = 1'b1;
                ctl.sp_inc = 1'b1;
            end
            S_LD_WAIT:  ctl.mem_cap = mem_rvalid;
            S_LD_WR:    ctl.mem_wr = 1'b1;
            S_ST_WR: begin
                ctl.mem_wr   = 1'b1;
                ctl.wsel_tos = 1'b1;
                ctl.sp_dec   = 1'b1;
            end
            S_ST_RD:    ctl.mem_rd = 1'b1;
            S_ST_WAIT:  ctl.mem_cap = mem_rvalid;
            default:    ctl = '0;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_FIN);

    // Only one extension select may drive the operand bus.
    assert_sel_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.sel_sx, ctl.sel_zx}));

    // Done lasts a single cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // An idle unit never touches memory.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ctl.mem_rd || ctl.mem_wr));

    // Reads and writes are never requested together.
    assert_rw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.mem_rd && ctl.mem_wr));

endmodule

// File: rtl/lvar_regs.sv
// Module: lvar_regs
// Architectural registers: stack pointer, local-variable base, top-of-stack,
// memory address and memory data. Driven purely by controller strobes;
// addresses wrap modulo 2**AW. Assumes at most one address-register source
// is active per cycle.
module lvar_regs
    import lvar_pkg::*;
#(
    parameter int          DW      = 32,
    parameter int          AW      = 10,
    parameter logic [AW-1:0] SP_INIT = '0,
    parameter logic [AW-1:0] LV_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lv_ctl_t       ctl,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] lv,
    output logic [DW-1:0] tos,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mdr
);
    logic [AW-1:0] sp_plus;
    logic [AW-1:0] sp_minus;
    logic [AW-1:0] idx_addr;

    // Address arithmetic shared by the update paths.
    always_comb begin
        sp_plus  = sp + AW'(1);
        sp_minus = sp - AW'(1);
        idx_addr = lv + opnd[AW-1:0];
    end

    // Stack pointer: moves up on push/load, down on store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= SP_INIT;
        else if (ctl.sp_inc)
            sp <= sp_plus;
        else if (ctl.sp_dec)
            sp <= sp_minus;
    end

    // Local-variable base: fixed frame for this unit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lv <= LV_INIT;
    end

    // Memory address register: variable address, or the moved stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mar <= '0;
        else if (ctl.mar_from_idx)
            mar <= idx_addr;
        else if (ctl.sp_inc)
            mar <= sp_plus;
        else if (ctl.sp_dec)
            mar <= sp_minus;
    end

    // Memory data register: push constant or returned read word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mdr <= '0;
        else if (ctl.mdr_from_bus)
            mdr <= opnd;
        else if (ctl.mem_cap)
            mdr <= rdata;
    end

    // Top-of-stack register: follows the pushed or fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tos <= '0;
        else if (ctl.tos_from_mdr)
            tos <= mdr;
        else if (ctl.mem_cap)
            tos <= rdata;
    end

    // Stack pointer and address register land on the same new slot.
    assert_sp_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sp_inc |=> (sp == $past(sp) + AW'(1)) && (mar == sp));

    assert_sp_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sp_dec |=> (sp == $past(sp) - AW'(1)) && (mar == sp));

    // The base never moves.
    assert_lv_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(lv));

endmodule

// File: rtl/lvar_stack_unit.sv
// Module: lvar_stack_unit (top)
// Executes byte push, local load and local store on a word-addressed memory
// with a one-cycle read latency. Connects the controller, the operand
// extender and the register file, and maps the strobes onto the memory port.
// Assumes 16 <= DW and AW <= 16.
module lvar_stack_unit
    import lvar_pkg::*;
#(
    parameter int            DW      = 32,
    parameter int            AW      = 10,
    parameter logic [AW-1:0] SP_INIT = AW'(512),
    parameter logic [AW-1:0] LV_INIT = AW'(64)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic          op_wide,
    input  logic [7:0]    imm_hi,
    input  logic [7:0]    imm_lo,
    output logic          busy,
    output logic          op_done,
    output logic [AW-1:0] sp_o,
    output logic [DW-1:0] tos_o,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    lv_ctl_t       ctl;
    logic [DW-1:0] opnd;
    logic [AW-1:0] lv;
    logic [AW-1:0] mar;
    logic [DW-1:0] mdr;

    lvar_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .mem_rvalid (mem_rvalid),
        .ctl        (ctl),
        .busy       (busy),
        .done       (op_done)
    );

    lvar_operand_ext #(.DW(DW)) u_ext (
        .sel_sx (ctl.sel_sx),
        .sel_zx (ctl.sel_zx),
        .wide   (op_wide),
        .hi     (imm_hi),
        .lo     (imm_lo),
        .bus    (opnd)
    );

    lvar_regs #(
        .DW      (DW),
        .AW      (AW),
        .SP_INIT (SP_INIT),
        .LV_INIT (LV_INIT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .opnd  (opnd),
        .rdata (mem_rdata),
        .sp    (sp_o),
        .lv    (lv),
        .tos   (tos_o),
        .mar   (mar),
        .mdr   (mdr)
    );

    // Memory port mapping: address always from the address register.
    always_comb begin
        mem_req   = ctl.mem_rd | ctl.mem_wr;
        mem_we    = ctl.mem_wr;
        mem_addr  = mar;
        mem_wdata = ctl.wsel_tos ? tos_o : mdr;
    end

    // A push constant lands sign-extended from the input byte.
    assert_push_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sel_sx |=> mdr == {{(DW-8){$past(imm_lo[7])}}, $past(imm_lo)});

    // A narrow index addresses base plus the unsigned byte.
    assert_narrow_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sel_zx && !op_wide) |=> mar == lv + AW'($past(imm_lo)));

    // A wide index addresses base plus the high/low pair.
    assert_wide_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sel_zx && op_wide) |=> mar == lv + AW'({$past(imm_hi), $past(imm_lo)}));

    // Push and load stack writes carry the new top-of-stack word.
    assert_wr_tos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !ctl.wsel_tos) |-> (mem_wdata == tos_o) && (mem_addr == sp_o));

    // After the store write the read follows at the lowered stack pointer.
    assert_store_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ctl.wsel_tos) |=> mem_req && !mem_we && (mem_addr == $past(sp_o) - AW'(1)));

endmodule

// File: tb/sim_lvar_stack_unit.sv
`timescale 1ns/1ps
module sim_lvar_stack_unit;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] SP0 = AW'(512);
    localparam logic [AW-1:0] LV0 = AW'(64);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_kind = 2'd0;
    logic          op_wide = 1'b0;
    logic [7:0]    imm_hi = 8'h0;
    logic [7:0]    imm_lo = 8'h0;
    logic          busy, op_done, mem_req, mem_we, mem_rvalid;
    logic [AW-1:0] sp_o, mem_addr;
    logic [DW-1:0] tos_o, mem_wdata, mem_rdata;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    logic [AW-1:0] exp_sp;
    logic [DW-1:0] exp_tos;

    int n_checks = 0;
    int n_fail = 0;
    bit timed_out = 0;

    always #2.5 clk = ~clk;

    lvar_stack_unit #(.DW(DW), .AW(AW), .SP_INIT(SP0), .LV_INIT(LV0)) u0 (
        .clk, .rst_n, .op_valid, .op_kind, .op_wide, .imm_hi, .imm_lo,
        .busy, .op_done, .sp_o, .tos_o, .mem_req, .mem_we, .mem_addr,
        .mem_wdata, .mem_rvalid, .mem_rdata
    );

    // Behavioural memory, one-cycle read latency.
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_we;
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sext8(input logic [7:0] b);
        return {{(DW-8){b[7]}}, b};
    endfunction

    function automatic logic [AW-1:0] var_addr(input logic wd, input logic [7:0] hi, input logic [7:0] lo);
        logic [15:0] idx = wd ? {hi, lo} : {8'h00, lo};
        return LV0 + idx[AW-1:0];
    endfunction

    // Reference model update for one operation (R1, R3..R7).
    task automatic model(input logic [1:0] kind, input logic wd, input logic [7:0] hi, input logic [7:0] lo);
        logic [AW-1:0] a;
        logic [DW-1:0] v;
        case (kind)
            2'd1: begin
                v = sext8(lo); exp_sp = exp_sp + 1'b1;
                exp_mem[exp_sp] = v; exp_tos = v;
            end
            2'd2: begin
                a = var_addr(wd, hi, lo); v = exp_mem[a];
                exp_sp = exp_sp + 1'b1; exp_mem[exp_sp] = v; exp_tos = v;
            end
            2'd3: begin
                a = var_addr(wd, hi, lo); exp_mem[a] = exp_tos;
                exp_sp = exp_sp - 1'b1; exp_tos = exp_mem[exp_sp];
            end
            default: ;
        endcase
    endtask

    // Issue one operation, optionally offering a second one while busy (R9).
    task automatic run_op(input logic [1:0] kind, input logic wd, input logic [7:0] hi,
                          input logic [7:0] lo, input bit poke, input string tag);
        int cyc;
        int lat_exp;
        logic [AW-1:0] a;
        a = var_addr(wd, hi, lo);
        lat_exp = (kind == 2'd1) ? 3 : 4;
        model(kind, wd, hi, lo);
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_wide = wd; imm_hi = hi; imm_lo = lo;
        @(negedge clk);
        cyc = 1;
        if (poke) begin
            op_kind = 2'd2; op_wide = 1'b0; imm_lo = 8'h05;
        end else begin
            op_valid = 1'b0;
        end
        while (!op_done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        op_valid = 1'b0;
        check({"R8 latency ", tag}, DW'(cyc), DW'(lat_exp));
        @(negedge clk);
        check({"R8 done pulse ", tag}, DW'(op_done), '0);
        check({"R9 idle after ", tag}, DW'(busy), '0);
        check({tag, " sp"}, DW'(sp_o), DW'(exp_sp));
        check({tag, " tos"}, tos_o, exp_tos);
        if (kind == 2'd3) check({"R5 var write ", tag}, mem[a], exp_mem[a]);
        else check({tag, " stack word"}, mem[exp_sp], exp_mem[exp_sp]);
    endtask

    initial begin
        #200000;
        timed_out = 1;
    end

    initial begin
        logic [AW-1:0] a;
        logic [15:0] d;
        logic [1:0] k;
        void'($urandom(32'd1357));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 32'h9E37_79B9 * (i + 1);
            exp_mem[i] = mem[i];
        end
        exp_sp = SP0;
        exp_tos = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", DW'(busy), '0);
        check("R11 done", DW'(op_done), '0);
        check("R11 mem_req", DW'(mem_req), '0);
        check("R11 sp", DW'(sp_o), DW'(SP0));
        check("R11 tos", tos_o, '0);
        rst_n = 1'b1;
        // R9: op_kind 0 is never accepted
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd0;
        @(negedge clk); @(negedge clk);
        check("R9 none op busy", DW'(busy), '0);
        op_valid = 1'b0;
        check("R9 none op sp", DW'(sp_o), DW'(exp_sp));
        // R1/R2: sign-extension boundaries
        run_op(2'd1, 1'b0, 8'h00, 8'h80, 0, "R1 push 80");
        run_op(2'd1, 1'b0, 8'h00, 8'h7F, 0, "R1 push 7F");
        run_op(2'd1, 1'b0, 8'h00, 8'hFF, 0, "R2 push FF");
        // R7: wide and high byte ignored on push
        run_op(2'd1, 1'b1, 8'hC3, 8'h11, 0, "R7 wide push");
        // R3/R2: narrow index above 0x7F is unsigned
        run_op(2'd2, 1'b0, 8'hAA, 8'hFF, 0, "R3 load FF");
        run_op(2'd2, 1'b0, 8'h00, 8'h80, 0, "R2 load 80");
        // R6: wide index high byte first
        run_op(2'd2, 1'b1, 8'h01, 8'h02, 0, "R6 wide load");
        run_op(2'd3, 1'b1, 8'h02, 8'h10, 0, "R6 wide store");
        // R5: store target equals the new stack top
        a = exp_sp - 1'b1 - LV0;
        d = 16'(a);
        run_op(2'd3, 1'b1, d[15:8], d[7:0], 0, "R5 store collide");
        check("R5 collide tos is stored", tos_o, exp_mem[exp_sp]);
        // R4: load source equals the new stack slot
        a = exp_sp + 1'b1 - LV0;
        d = 16'(a);
        run_op(2'd2, 1'b1, d[15:8], d[7:0], 0, "R4 load collide");
        // R9: second op offered while busy is ignored
        run_op(2'd1, 1'b0, 8'h00, 8'h3C, 1, "R9 busy push");
        run_op(2'd3, 1'b0, 8'h00, 8'h07, 1, "R9 busy store");
        // Random mix (R10 covered by every load/store)
        for (int n = 0; n < 300 && !timed_out; n++) begin
            k = 2'($urandom_range(1, 3));
            run_op(k, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom), 0,
                   k == 2'd1 ? "R1 rnd push" : (k == 2'd2 ? "R4 rnd load" : "R5 rnd store"));
        end
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) bad++;
            check("R10 final memory image mismatches", DW'(bad), '0);
        end
        if (timed_out) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog that still reaches the summary line.
    initial begin
        wait (timed_out);
        #100;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule